// File: doc/BRIEF.md
# Differential Pre-Driver Skew and Duty Calibrator

This block is the digital controller that trims the two legs of a differential, inverter-based pre-driver. When calibration is enabled, it switches the pre-driver input from the data stream to a calibration clock. It then closes a delay-locked loop on the rising-edge delay of the adjustable leg. The loop is driven by a one-bit early/late phase detector and runs until the two outputs line up.

Once that loop has finished, two duty-cycle loops start and run side by side, one per leg. Each loop steps the falling-edge delay code of its leg. It follows a comparator that reports whether the low-pass average of that leg's output sits above mid-supply. Successive duty updates are spaced by a programmable settle interval so that the analog average can catch up. The duty loops never touch the rising-edge code, so the phase alignment survives. The first leg keeps a fixed rising delay outside this block; only its falling code is driven here.

Each loop stops on its own. It stops when it sees a fixed number of consecutive direction reversals (lock), or when a step would leave the 5-bit code range (exhaustion). When enable is dropped, the mux returns to data and every code freezes at its latest value.

Top module: `pdc_skew_duty_cal`

## Requirements
- R1: `sel_clk` is 1 exactly while the phase loop or the duty loops are running. It is 0 in idle, after calibration completes, and from the cycle after `cal_en` is sampled low.
- R2: After reset, all three codes equal 16, `sel_clk` is 0, and every status flag is 0.
- R3: The phase loop samples `ph_late` on every clock while running. With `ph_late` = 1 it lowers `rise_code_b` by one; with 0 it raises it by one. The falling codes do not move while the phase loop runs.
- R4: A loop declares lock after 4 consecutive updates that each reverse the previous direction. A repeat of the same direction restarts that count. The update that makes the fourth reversal is still applied. Phase lock is shown on `ph_lock`.
- R5: The duty loops make no update until the phase loop has finished. Each duty loop lowers its falling code by one when its `duty_hi_*` bit is 1 and raises it by one when that bit is 0.
- R6: The two duty loops update on the same strobes. Each stops independently and reports its own lock (`duty_lock_a`, `duty_lock_b`). `rise_code_b` never changes once the duty loops are running.
- R7: Two successive updates of one duty loop are exactly `settle_len`+1 cycles apart. The first duty update also waits for a full settle interval after the phase loop finishes.
- R8: A step that would move a code below 0 or above 31 leaves the code unchanged. It ends that loop without lock and sets `range_hit`, and the sequence continues: to the duty loops after the phase loop, or to completion after the duty loops.
- R9: Sampling `cal_en` low stops all loops and holds all codes. Raising `cal_en` again clears every flag and restarts calibration from the held codes.
- R10: `cal_done` rises once both duty loops have stopped. It and all codes stay unchanged while `cal_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_en | input | 1 | Calibration enable; rising from idle starts a run |
| settle_len | input | 8 | Settle cycles between duty updates |
| ph_late | input | 1 | Phase detector: adjustable leg lags (1) or leads (0) |
| duty_hi_a | input | 1 | Leg A averaged output above mid-supply |
| duty_hi_b | input | 1 | Leg B averaged output above mid-supply |
| sel_clk | output | 1 | Pre-driver input mux: 1 = calibration clock, 0 = data |
| rise_code_b | output | 5 | Leg B rising-edge delay code |
| fall_code_a | output | 5 | Leg A falling-edge delay code |
| fall_code_b | output | 5 | Leg B falling-edge delay code |
| ph_lock | output | 1 | Phase loop locked |
| duty_lock_a | output | 1 | Leg A duty loop locked |
| duty_lock_b | output | 1 | Leg B duty loop locked |
| range_hit | output | 1 | Some loop tried to step past a code limit |
| cal_done | output | 1 | Both duty loops finished |

## Verification
Behavioural comparator models close each loop around a target code, so every loop settles into a dither that the bench predicts exactly.

- **Target patterns:**
  - Mid-range targets show direction and lock.
  - A target equal to the start code shows lock reached by pure dithering.
  - A target out of reach above, or pinned at zero, separates saturation from lock and shows that the sequence still moves on.
- **Settle lengths:** zero and non-zero settle lengths show whether update spacing follows the programmed value.
- **Aborts and idle:** aborts in both loop phases, plus a long idle while done, show that codes freeze and that restart resumes from them.
- **Random runs:** seeded random targets and settle lengths cover mixed orderings of lock and exhaustion across the two duty legs.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
    localparam int DEF_CODE_W   = 5;
    localparam int DEF_SETTLE_W = 8;
    localparam int DEF_LOCK_REV = 4;
    localparam int DEF_INIT     = 16;
    localparam int NUM_LEGS     = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PHASE = 2'd1,
        ST_DUTY  = 2'd2,
        ST_DONE  = 2'd3
    } cal_state_e;

    typedef struct packed {
        logic locked;
        logic exhausted;
    } loop_flags_t;

    // A step is blocked when it would leave the code range.
    function automatic logic step_blocked(input logic up, input logic at_max, input logic at_min);
        return up ? at_max : at_min;
    endfunction

    function automatic logic loop_finished(input loop_flags_t f);
        return f.locked | f.exhausted;
    endfunction
endpackage

// File: rtl/pdc_step_loop.sv
`timescale 1ns/1ps
module pdc_step_loop
    import pdc_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int LOCK_REV  = DEF_LOCK_REV,
    parameter int INIT_CODE = DEF_INIT
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              strobe,
    input  logic              step_up,
    output logic [CODE_W-1:0] code,
    output loop_flags_t       flags
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam int REV_W = $clog2(LOCK_REV + 1);
    localparam logic [REV_W-1:0] REV_LAST = REV_W'(LOCK_REV - 1);

    logic [CODE_W-1:0] code_q;
    logic              have_prev_q;
    logic              last_up_q;
    logic [REV_W-1:0]  rev_q;
    loop_flags_t       flags_q;

    logic busy;
    logic blocked;
    logic reversal;

    assign busy     = strobe && !loop_finished(flags_q);
    assign blocked  = step_blocked(step_up, code_q == CODE_MAX, code_q == '0);
    assign reversal = have_prev_q && (step_up != last_up_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q      <= CODE_W'(INIT_CODE);
            have_prev_q <= 1'b0;
            last_up_q   <= 1'b0;
            rev_q       <= '0;
            flags_q     <= '0;
        end else if (clear) begin
            have_prev_q <= 1'b0;
            rev_q       <= '0;
            flags_q     <= '0;
        end else if (busy) begin
            if (blocked) begin
                flags_q.exhausted <= 1'b1;
            end else begin
                code_q      <= step_up ? code_q + 1'b1 : code_q - 1'b1;
                have_prev_q <= 1'b1;
                last_up_q   <= step_up;
                if (reversal) begin
                    rev_q <= rev_q + 1'b1;
                    if (rev_q == REV_LAST) begin
                        flags_q.locked <= 1'b1;
                    end
                end else begin
                    rev_q <= '0;
                end
            end
        end
    end

    assign code  = code_q;
    assign flags = flags_q;
endmodule

// File: rtl/pdc_settle_timer.sv
`timescale 1ns/1ps
module pdc_settle_timer #(
    parameter int SETTLE_W = 8
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SETTLE_W-1:0] len,
    output logic                expired
);
    logic [SETTLE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pdc_seq.sv
`timescale 1ns/1ps
module pdc_seq
    import pdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_en,
    input  logic       ph_fin,
    input  logic       duty_fin,
    output cal_state_e state,
    output logic       start
);
    cal_state_e st_q;
    cal_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cal_en) st_d = ST_PHASE;
            ST_PHASE: if (!cal_en) st_d = ST_IDLE; else if (ph_fin) st_d = ST_DUTY;
            ST_DUTY:  if (!cal_en) st_d = ST_IDLE; else if (duty_fin) st_d = ST_DONE;
            ST_DONE:  if (!cal_en) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign state = st_q;
    assign start = (st_q == ST_IDLE) && cal_en;
endmodule

// File: rtl/pdc_skew_duty_cal.sv
`timescale 1ns/1ps
module pdc_skew_duty_cal
    import pdc_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int SETTLE_W  = DEF_SETTLE_W,
    parameter int LOCK_REV  = DEF_LOCK_REV,
    parameter int INIT_CODE = DEF_INIT
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_en,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                ph_late,
    input  logic                duty_hi_a,
    input  logic                duty_hi_b,
    output logic                sel_clk,
    output logic [CODE_W-1:0]   rise_code_b,
    output logic [CODE_W-1:0]   fall_code_a,
    output logic [CODE_W-1:0]   fall_code_b,
    output logic                ph_lock,
    output logic                duty_lock_a,
    output logic                duty_lock_b,
    output logic                range_hit,
    output logic                cal_done
);
    cal_state_e        cur_st;
    logic              start;
    loop_flags_t       ph_fl;
    logic              ph_fin;
    logic              ph_strobe;
    logic              duty_strobe;
    logic              tmr_load;
    logic              tmr_expired;
    logic [NUM_LEGS-1:0] duty_up;
    logic [NUM_LEGS-1:0] duty_lock;
    logic [NUM_LEGS-1:0] duty_exh;
    logic [NUM_LEGS-1:0] duty_fin;
    logic [CODE_W-1:0]   fall_codes [NUM_LEGS];

    assign ph_fin      = loop_finished(ph_fl);
    assign ph_strobe   = (cur_st == ST_PHASE) && cal_en;
    assign duty_strobe = (cur_st == ST_DUTY) && cal_en && tmr_expired;
    assign tmr_load    = (ph_strobe && ph_fin) || duty_strobe;
    assign duty_up     = ~{duty_hi_b, duty_hi_a};

    pdc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cal_en   (cal_en),
        .ph_fin   (ph_fin),
        .duty_fin (&duty_fin),
        .state    (cur_st),
        .start    (start)
    );

    pdc_step_loop #(
        .CODE_W    (CODE_W),
        .LOCK_REV  (LOCK_REV),
        .INIT_CODE (INIT_CODE)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .strobe  (ph_strobe),
        .step_up (!ph_late),
        .code    (rise_code_b),
        .flags   (ph_fl)
    );

    pdc_settle_timer #(
        .SETTLE_W (SETTLE_W)
    ) u_settle (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .len     (settle_len),
        .expired (tmr_expired)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        loop_flags_t leg_fl;
        pdc_step_loop #(
            .CODE_W    (CODE_W),
            .LOCK_REV  (LOCK_REV),
            .INIT_CODE (INIT_CODE)
        ) u_duty (
            .clk     (clk),
            .rst     (rst),
            .clear   (start),
            .strobe  (duty_strobe),
            .step_up (duty_up[g]),
            .code    (fall_codes[g]),
            .flags   (leg_fl)
        );
        assign duty_lock[g] = leg_fl.locked;
        assign duty_exh[g]  = leg_fl.exhausted;
        assign duty_fin[g]  = loop_finished(leg_fl);
    end

    assign fall_code_a = fall_codes[0];
    assign fall_code_b = fall_codes[1];
    assign sel_clk     = (cur_st == ST_PHASE) || (cur_st == ST_DUTY);
    assign ph_lock     = ph_fl.locked;
    assign duty_lock_a = duty_lock[0];
    assign duty_lock_b = duty_lock[1];
    assign range_hit   = ph_fl.exhausted | (|duty_exh);
    assign cal_done    = (cur_st == ST_DONE);
endmodule

// File: rtl/pdc_checker.sv
`timescale 1ns/1ps
module pdc_checker
    import pdc_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
)(
    input logic              clk,
    input logic              rst,
    input logic              cal_en,
    input cal_state_e        cur_st,
    input logic              sel_clk,
    input logic [CODE_W-1:0] rise_code_b,
    input logic [CODE_W-1:0] fall_code_a,
    input logic [CODE_W-1:0] fall_code_b,
    input logic              duty_lock_a,
    input logic              duty_lock_b,
    input logic              range_hit,
    input logic              cal_done
);
    AST_DATA_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !cal_en |=> !sel_clk); // R1

    AST_RISE_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(rise_code_b) |-> (rise_code_b == CODE_W'($past(rise_code_b) + 1'b1)
                                || rise_code_b == CODE_W'($past(rise_code_b) - 1'b1))); // R3

    AST_FALL_ONLY_IN_DUTY: assert property (@(posedge clk) disable iff (rst)
        (!$stable(fall_code_a) || !$stable(fall_code_b)) |-> ($past(cur_st) == ST_DUTY)); // R5

    AST_RISE_FROZEN_IN_DUTY: assert property (@(posedge clk) disable iff (rst)
        (cur_st == ST_DUTY) |=> $stable(rise_code_b)); // R6

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !cal_en |=> ($stable(rise_code_b) && $stable(fall_code_a) && $stable(fall_code_b))); // R9

    AST_DONE_BOTH_STOPPED: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> ((duty_lock_a || range_hit) && (duty_lock_b || range_hit))); // R10
endmodule

bind pdc_skew_duty_cal pdc_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cal_en      (cal_en),
    .cur_st      (cur_st),
    .sel_clk     (sel_clk),
    .rise_code_b (rise_code_b),
    .fall_code_a (fall_code_a),
    .fall_code_b (fall_code_b),
    .duty_lock_a (duty_lock_a),
    .duty_lock_b (duty_lock_b),
    .range_hit   (range_hit),
    .cal_done    (cal_done)
);

// File: tb/pdc_skew_duty_cal_tb.sv
`timescale 1ns/1ps
module pdc_skew_duty_cal_tb;
    localparam int CW = 5;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cal_en = 1'b0;
    logic [SW-1:0] settle_len = 8'd3;
    logic          ph_late, duty_hi_a, duty_hi_b;
    logic          sel_clk, ph_lock, duty_lock_a, duty_lock_b, range_hit, cal_done;
    logic [CW-1:0] rise_code_b, fall_code_a, fall_code_b;

    int ph_tgt = 16, a_tgt = 16, b_tgt = 16;
    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // Behavioural plant: detector/comparators referenced to target codes.
    always_comb begin
        ph_late   = (int'(rise_code_b) >= ph_tgt);
        duty_hi_a = (int'(fall_code_a) >= a_tgt);
        duty_hi_b = (int'(fall_code_b) >= b_tgt);
    end

    pdc_skew_duty_cal u_dut (
        .clk(clk), .rst(rst), .cal_en(cal_en), .settle_len(settle_len),
        .ph_late(ph_late), .duty_hi_a(duty_hi_a), .duty_hi_b(duty_hi_b),
        .sel_clk(sel_clk), .rise_code_b(rise_code_b), .fall_code_a(fall_code_a),
        .fall_code_b(fall_code_b), .ph_lock(ph_lock), .duty_lock_a(duty_lock_a),
        .duty_lock_b(duty_lock_b), .range_hit(range_hit), .cal_done(cal_done)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected loop outcome: unit steps toward target, lock on 4th reversal, stop at range edge.
    function automatic void ref_loop(input int start, input int tgt, output int fin, output bit lk, output bit sat);
        int c; int rv; bit hp; bit lu; bit up;
        c = start; rv = 0; hp = 0; lu = 0; lk = 0; sat = 0;
        for (int k = 0; k < 200; k++) begin
            up = (c < tgt);
            if ((up && c == 31) || (!up && c == 0)) begin sat = 1; break; end
            c = up ? c + 1 : c - 1;
            if (hp && up != lu) begin
                rv++;
                if (rv == 4) begin lk = 1; break; end
            end else begin
                rv = 0;
            end
            lu = up; hp = 1;
        end
        fin = c;
    endfunction

    // Monitor: duty spacing, ordering of falling vs rising updates.
    int cyc = 0, run_id = 0, mon_run = -1, cur_settle = 3;
    int last_a = 0, last_b = 0;
    bit seen_a = 0, seen_b = 0, duty_moved = 0;
    logic [CW-1:0] pr, pa, pb;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (mon_run != run_id) begin
                mon_run = run_id; seen_a = 0; seen_b = 0; duty_moved = 0;
            end
            if (fall_code_a != pa) begin
                chk(ph_lock || range_hit, "R5", "leg a falling code moved before phase end", int'(ph_lock), 1);
                if (seen_a) chk(cyc - last_a == cur_settle + 1, "R7", "leg a update spacing", cyc - last_a, cur_settle + 1);
                seen_a = 1; last_a = cyc; duty_moved = 1;
            end
            if (fall_code_b != pb) begin
                chk(ph_lock || range_hit, "R5", "leg b falling code moved before phase end", int'(ph_lock), 1);
                if (seen_b) chk(cyc - last_b == cur_settle + 1, "R7", "leg b update spacing", cyc - last_b, cur_settle + 1);
                seen_b = 1; last_b = cyc; duty_moved = 1;
            end
            if (rise_code_b != pr)
                chk(!duty_moved, "R6", "rising code moved during duty loops", int'(rise_code_b), int'(pr));
        end
        pr = rise_code_b; pa = fall_code_a; pb = fall_code_b;
    end

    task automatic stop_cal();
        @(negedge clk) cal_en = 1'b0;
        @(negedge clk);
        chk(sel_clk == 1'b0, "R1", "mux after enable low", int'(sel_clk), 0);
    endtask

    task automatic run_cal(input int pt, input int at, input int bt, input int sl);
        int e_r, e_a, e_b, s_r, first, n;
        bit lk_r, sa_r, lk_a, sa_a, lk_b, sa_b;
        s_r = int'(rise_code_b);
        ref_loop(s_r, pt, e_r, lk_r, sa_r);
        ref_loop(int'(fall_code_a), at, e_a, lk_a, sa_a);
        ref_loop(int'(fall_code_b), bt, e_b, lk_b, sa_b);
        ph_tgt = pt; a_tgt = at; b_tgt = bt;
        settle_len = SW'(sl); cur_settle = sl; run_id++;
        @(negedge clk) cal_en = 1'b1;
        @(negedge clk);
        chk(sel_clk == 1'b1, "R1", "mux during phase loop", int'(sel_clk), 1);
        chk(!ph_lock && !range_hit && !cal_done, "R9", "flags cleared on start", int'(ph_lock) + int'(range_hit), 0);
        @(negedge clk);
        if (s_r < pt) first = (s_r == 31) ? s_r : s_r + 1;
        else          first = (s_r == 0) ? s_r : s_r - 1;
        chk(int'(rise_code_b) == first, "R3", "first phase step", int'(rise_code_b), first);
        n = 0;
        while (!cal_done && n < 3000) begin @(negedge clk); n++; end
        chk(cal_done == 1'b1, "R10", "done reached", int'(cal_done), 1);
        chk(int'(rise_code_b) == e_r, "R4", "final rising code", int'(rise_code_b), e_r);
        chk(ph_lock == lk_r, "R4", "phase lock flag", int'(ph_lock), int'(lk_r));
        chk(int'(fall_code_a) == e_a, "R5", "final leg a falling code", int'(fall_code_a), e_a);
        chk(int'(fall_code_b) == e_b, "R5", "final leg b falling code", int'(fall_code_b), e_b);
        chk(duty_lock_a == lk_a, "R6", "leg a lock flag", int'(duty_lock_a), int'(lk_a));
        chk(duty_lock_b == lk_b, "R6", "leg b lock flag", int'(duty_lock_b), int'(lk_b));
        chk(range_hit == (sa_r | sa_a | sa_b), "R8", "range flag", int'(range_hit), int'(sa_r | sa_a | sa_b));
        chk(sel_clk == 1'b0, "R1", "mux back to data when done", int'(sel_clk), 0);
    endtask

    initial begin
        logic [CW-1:0] hr, ha, hb;
        void'($urandom(32'd91733));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rise_code_b == 5'd16 && fall_code_a == 5'd16 && fall_code_b == 5'd16, "R2", "reset codes", int'(rise_code_b), 16);
        chk(!sel_clk && !ph_lock && !duty_lock_a && !duty_lock_b && !range_hit && !cal_done,
            "R2", "reset flags", int'(sel_clk) + int'(cal_done), 0);

        run_cal(20, 10, 25, 3);
        // R10: done holds with enable high even as targets move
        hr = rise_code_b; ha = fall_code_a; hb = fall_code_b;
        ph_tgt = 2; a_tgt = 29; b_tgt = 3;
        repeat (15) @(negedge clk);
        chk(cal_done && rise_code_b == hr && fall_code_a == ha && fall_code_b == hb, "R10", "hold while done", int'(rise_code_b), int'(hr));
        stop_cal();

        run_cal(int'(rise_code_b), int'(fall_code_a), 7, 0);  // dither lock, zero settle
        stop_cal();
        run_cal(40, 12, 12, 2);                               // R8 phase exhausts upward
        chk(rise_code_b == 5'd31 && !ph_lock, "R8", "phase saturated at 31", int'(rise_code_b), 31);
        stop_cal();
        run_cal(15, 0, 18, 1);                                // R8 leg a exhausts at 0
        chk(fall_code_a == 5'd0 && !duty_lock_a && duty_lock_b, "R8", "leg a saturated at 0", int'(fall_code_a), 0);
        stop_cal();

        // R9: abort during phase loop
        run_id++; ph_tgt = 28; a_tgt = 5; b_tgt = 5; cur_settle = 2; settle_len = 8'd2;
        @(negedge clk) cal_en = 1'b1;
        repeat (4) @(negedge clk);
        cal_en = 1'b0;
        @(negedge clk);
        chk(sel_clk == 1'b0, "R1", "mux after abort", int'(sel_clk), 0);
        hr = rise_code_b; ha = fall_code_a; hb = fall_code_b;
        ph_tgt = 0; a_tgt = 31; b_tgt = 31;
        repeat (10) @(negedge clk);
        chk(rise_code_b == hr && fall_code_a == ha && fall_code_b == hb, "R9", "codes held after phase abort", int'(rise_code_b), int'(hr));
        chk(!cal_done, "R9", "no done after abort", int'(cal_done), 0);

        // R9: abort during duty loops, then resume from held codes
        run_id++; ph_tgt = int'(rise_code_b) + 2; a_tgt = 2; b_tgt = 30;
        @(negedge clk) cal_en = 1'b1;
        while (!ph_lock) @(negedge clk);
        repeat (8) @(negedge clk);
        cal_en = 1'b0;
        @(negedge clk);
        hr = rise_code_b; ha = fall_code_a; hb = fall_code_b;
        repeat (10) @(negedge clk);
        chk(fall_code_a == ha && fall_code_b == hb && rise_code_b == hr, "R9", "codes held after duty abort", int'(fall_code_a), int'(ha));
        run_cal(int'(rise_code_b), 2, 30, 2);
        stop_cal();

        for (int i = 0; i < 6; i++) begin
            run_cal(int'($urandom_range(2, 29)), int'($urandom_range(2, 29)),
                    int'($urandom_range(2, 29)), int'($urandom_range(0, 6)));
            stop_cal();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule